// File: doc/BRIEF.md
# Programmable Event Timer Channel

A single timer channel whose count register is either 16 or 32 bits wide. On each counting tick it advances by one. The tick comes from the system clock, or from the rising edges of a slower alternate clock input after that input has been synchronised. The channel compares its count against a programmable target value. It also detects when the count wraps past its all-ones maximum. Each of these two events sets its own sticky flag in the mode register. Each can optionally request an interrupt and clear the channel's interrupt flag.

Software-side logic drives three write ports: count, target and mode. It reads the count, target and mode back on three output buses. The channel has one interrupt request line toward a shared interrupt controller. On a channel built with gating, two encodings of the low mode field freeze the counter. All other encodings of that field leave counting as normal.

Top module: `timer_channel`

## Requirements
- R1: After reset the count, target, mode and `irq_o` are all zero.
- R2: Counting without the alternate clock (mode bit 8 clear): the count rises by one at every clock edge that has no write in its cycle. A count write loads the low WIDTH bits of the data at that edge. Any write (count, target or mode) suppresses the increment for its cycle.
- R3: A mode write loads all 16 bits of the data into the mode register, with bit 10 (interrupt flag) forced to 1.
- R4: When a tick arrives while the count equals an armed, nonzero target, the target event fires. It sets mode bit 11. The count then becomes 0 if mode bit 3 is set, and count+1 otherwise.
- R5: When a tick arrives while the count is all ones, the overflow event fires. The count becomes 0 and mode bit 12 is set.
- R6: An event whose enable is set requests an interrupt: mode bit 4 for the target event, mode bit 5 for the overflow event. `irq_o` is then high for the cycle after that edge, and mode bit 10 is cleared at the same edge.
- R7: An event whose enable is clear still sets its flag. It leaves `irq_o` low and mode bit 10 unchanged.
- R8: A target of 0 never fires.
- R9: A target write loads the target and arms the target only if the written value is above the current count. An unarmed target fires only after the next overflow, which re-arms it. A count write also re-arms it.
- R10: With mode bit 8 set, one tick is taken per rising edge of `alt_clk_i`. The count changes at the third system clock edge after `alt_clk_i` rises, because the input passes two synchroniser stages.
- R11: When the channel is built with gating, mode bits 2:0 equal to 3'b001 or 3'b111 stop all counting and events. Writes still take effect.
- R12: If the target event and the overflow event fall on the same tick, both flags are set and the count ends at 0. `irq_o` goes high if either enable is set.
- R13: Flags 11 and 12 stay set until a mode write replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_clk_i | input | 1 | Alternate count clock, asynchronous to `clk` |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | WIDTH | Count write data |
| tgt_we_i | input | 1 | Target write strobe |
| tgt_wdata_i | input | WIDTH | Target write data |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 16 | Mode write data |
| count_o | output | WIDTH | Current count |
| target_o | output | WIDTH | Current target |
| mode_o | output | 16 | Mode register, flags included |
| irq_o | output | 1 | Interrupt request, one cycle per enabled event |

## Verification
The target event and the overflow event can land on the same tick. This happens when the target is all ones and the count steps off that value. The collision is provoked directly by loading the count just below the maximum with the target at the maximum and both enables set. Random count writes near the top of the range also reach it. The result is judged at the edge of the collision. The count must read 0, both flag bits must be set, the interrupt flag must be clear and `irq_o` must be high, all matched against a cycle-level reference model held in the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int MODE_W = 16;

    // mode register bit positions
    localparam int MB_RST_TGT  = 3;
    localparam int MB_IE_TGT   = 4;
    localparam int MB_IE_OVF   = 5;
    localparam int MB_ALT_CLK  = 8;
    localparam int MB_IRQ_FLAG = 10;
    localparam int MB_TGT_FLAG = 11;
    localparam int MB_OVF_FLAG = 12;

    typedef enum logic {
        CLK_SYS = 1'b0,
        CLK_ALT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic tgt_hit;
        logic ovf_hit;
    } evt_t;

    // gate encodings that freeze a gate-capable channel
    function automatic logic gate_halts(input logic [2:0] gate);
        return (gate == 3'b001) || (gate == 3'b111);
    endfunction

endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alt_clk_i,
    input  timer_pkg::clk_src_e src_i,
    input  logic               halt_i,
    input  logic               hold_i,
    output logic               tick_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] sync_q;
    logic             alt_edge;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= alt_clk_i;
    end

    for (genvar i = 1; i < CHAIN; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
        end
    end

    assign alt_edge = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
    assign tick_o   = !hold_i && !halt_i &&
                      ((src_i == timer_pkg::CLK_ALT) ? alt_edge : 1'b1);

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cnt_we_i,
    input  logic [WIDTH-1:0]  cnt_wdata_i,
    input  logic              tgt_we_i,
    input  logic [WIDTH-1:0]  tgt_wdata_i,
    input  logic              rst_on_tgt_i,
    output logic [WIDTH-1:0]  count_o,
    output logic [WIDTH-1:0]  target_o,
    output timer_pkg::evt_t   evt_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic [WIDTH-1:0] count_q, target_q;
    logic             armed_q;
    logic             wrap_now;

    assign evt_o.tgt_hit = tick_i && armed_q && (target_q != '0) && (count_q == target_q);
    assign evt_o.ovf_hit = tick_i && (count_q == CNT_MAX);
    assign wrap_now      = (evt_o.tgt_hit && rst_on_tgt_i) || evt_o.ovf_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            target_q <= '0;
            armed_q  <= 1'b1;
        end else begin
            if (cnt_we_i)        count_q <= cnt_wdata_i;
            else if (tick_i)     count_q <= wrap_now ? '0 : count_q + 1'b1;

            if (tgt_we_i)        target_q <= tgt_wdata_i;

            if (cnt_we_i)            armed_q <= 1'b1;
            else if (tgt_we_i)       armed_q <= (tgt_wdata_i > count_q);
            else if (evt_o.ovf_hit)  armed_q <= 1'b1;
        end
    end

    assign count_o  = count_q;
    assign target_o = target_q;

    // R5: a tick at the maximum wraps the count to zero
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cnt_we_i && count_q == CNT_MAX) |=> (count_q == '0));

    // R9: a target written at or below the count cannot fire next cycle
    assert_early_target_R9: assert property (@(posedge clk) disable iff (rst)
        (tgt_we_i && !cnt_we_i && tgt_wdata_i <= count_q) |=> !evt_o.tgt_hit);

endmodule

// File: rtl/timer_mode_reg.sv
module timer_mode_reg (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_we_i,
    input  logic [timer_pkg::MODE_W-1:0]  mode_wdata_i,
    input  timer_pkg::evt_t               evt_i,
    output logic [timer_pkg::MODE_W-1:0]  mode_o,
    output logic                          irq_o
);
    import timer_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic              irq_q;
    logic              fire;

    assign fire = (evt_i.tgt_hit && mode_q[MB_IE_TGT]) ||
                  (evt_i.ovf_hit && mode_q[MB_IE_OVF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= fire;
            if (mode_we_i) begin
                mode_q              <= mode_wdata_i;
                mode_q[MB_IRQ_FLAG] <= 1'b1;
            end else begin
                if (evt_i.tgt_hit) mode_q[MB_TGT_FLAG] <= 1'b1;
                if (evt_i.ovf_hit) mode_q[MB_OVF_FLAG] <= 1'b1;
                if (fire)          mode_q[MB_IRQ_FLAG] <= 1'b0;
            end
        end
    end

    assign mode_o = mode_q;
    assign irq_o  = irq_q;

    // R3: every mode write leaves the interrupt flag set
    assert_mode_write_flag_R3: assert property (@(posedge clk) disable iff (rst)
        mode_we_i |=> mode_q[MB_IRQ_FLAG]);

    // R6: a request is always accompanied by a cleared interrupt flag
    assert_irq_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> !mode_q[MB_IRQ_FLAG]);

    // R13: the target flag stays set until a mode write
    assert_sticky_target_R13: assert property (@(posedge clk) disable iff (rst)
        (mode_q[MB_TGT_FLAG] && !mode_we_i) |=> mode_q[MB_TGT_FLAG]);

endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
    parameter int WIDTH       = 16,
    parameter bit GATE_EN     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alt_clk_i,
    input  logic                          cnt_we_i,
    input  logic [WIDTH-1:0]              cnt_wdata_i,
    input  logic                          tgt_we_i,
    input  logic [WIDTH-1:0]              tgt_wdata_i,
    input  logic                          mode_we_i,
    input  logic [timer_pkg::MODE_W-1:0]  mode_wdata_i,
    output logic [WIDTH-1:0]              count_o,
    output logic [WIDTH-1:0]              target_o,
    output logic [timer_pkg::MODE_W-1:0]  mode_o,
    output logic                          irq_o
);
    import timer_pkg::*;

    logic     halt, any_write, tick;
    clk_src_e src;
    evt_t     evt;

    assign any_write = cnt_we_i | tgt_we_i | mode_we_i;
    assign src       = mode_o[MB_ALT_CLK] ? CLK_ALT : CLK_SYS;

    if (GATE_EN) begin : g_gate
        assign halt = gate_halts(mode_o[2:0]);
    end else begin : g_nogate
        assign halt = 1'b0;
    end

    timer_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .alt_clk_i(alt_clk_i),
        .src_i    (src),
        .halt_i   (halt),
        .hold_i   (any_write),
        .tick_o   (tick)
    );

    timer_count_core #(.WIDTH(WIDTH)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .tgt_we_i    (tgt_we_i),
        .tgt_wdata_i (tgt_wdata_i),
        .rst_on_tgt_i(mode_o[MB_RST_TGT]),
        .count_o     (count_o),
        .target_o    (target_o),
        .evt_o       (evt)
    );

    timer_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .mode_we_i   (mode_we_i),
        .mode_wdata_i(mode_wdata_i),
        .evt_i       (evt),
        .mode_o      (mode_o),
        .irq_o       (irq_o)
    );

    // R11: a halting gate code freezes the count unless it is written
    assert_gate_halt_R11: assert property (@(posedge clk) disable iff (rst)
        (halt && !cnt_we_i) |=> $stable(count_o));

    // R8: a zero target never raises the target flag
    assert_zero_target_R8: assert property (@(posedge clk) disable iff (rst)
        (target_o == '0 && !mode_we_i && !mode_o[MB_TGT_FLAG]) |=> !mode_o[MB_TGT_FLAG]);

endmodule

// File: tb/timer_channel_tb.sv
module timer_channel_tb;
    localparam int W = 16;
    localparam logic [W-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alt_clk = 1'b0;
    logic          cnt_we = 1'b0, tgt_we = 1'b0, mode_we = 1'b0;
    logic [W-1:0]  cnt_wd = '0, tgt_wd = '0;
    logic [15:0]   mode_wd = '0;
    logic [W-1:0]  count, target;
    logic [15:0]   mode;
    logic          irq;

    int n_run = 0, n_fail = 0;

    // reference model state
    logic [W-1:0]  m_cnt, m_tgt;
    logic [15:0]   m_mode;
    logic          m_arm, m_irq;
    logic [2:0]    m_sync;

    always #2.5 clk = ~clk;

    timer_channel #(.WIDTH(W), .GATE_EN(1'b1), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .alt_clk_i(alt_clk),
        .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
        .tgt_we_i(tgt_we), .tgt_wdata_i(tgt_wd),
        .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
        .count_o(count), .target_o(target), .mode_o(mode), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic halting(input logic [15:0] md);
        return (md[2:0] == 3'b001) || (md[2:0] == 3'b111);
    endfunction

    task automatic model_update();
        logic tick, tev, oev, fire, wr;
        if (rst) begin
            m_cnt = '0; m_tgt = '0; m_mode = '0; m_arm = 1'b1; m_irq = 1'b0; m_sync = '0;
            return;
        end
        wr   = cnt_we | tgt_we | mode_we;
        tick = !wr && !halting(m_mode) && (m_mode[8] ? (m_sync[1] && !m_sync[2]) : 1'b1);
        tev  = tick && m_arm && (m_tgt != '0) && (m_cnt == m_tgt);
        oev  = tick && (m_cnt == MAXV);
        fire = (tev && m_mode[4]) || (oev && m_mode[5]);
        m_irq = fire;
        if (mode_we) m_mode = mode_wd | 16'h0400;
        if (tgt_we) begin
            if (!cnt_we) m_arm = (tgt_wd > m_cnt);
            m_tgt = tgt_wd;
        end
        if (cnt_we) begin
            m_cnt = cnt_wd; m_arm = 1'b1;
        end else if (tick) begin
            m_cnt = ((tev && m_mode[3]) || oev) ? '0 : m_cnt + 1'b1;
            if (tev) m_mode[11] = 1'b1;
            if (oev) begin m_mode[12] = 1'b1; m_arm = 1'b1; end
            if (fire) m_mode[10] = 1'b0;
        end
        m_sync = {m_sync[1:0], alt_clk};
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R2 count vs model", 32'(count), 32'(m_cnt));
        check("R9 target vs model", 32'(target), 32'(m_tgt));
        check("R4 mode vs model", 32'(mode), 32'(m_mode));
        check("R6 irq vs model", 32'(irq), 32'(m_irq));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_mode(input logic [15:0] v);
        mode_we = 1'b1; mode_wd = v; step(); mode_we = 1'b0;
    endtask
    task automatic wr_cnt(input logic [W-1:0] v);
        cnt_we = 1'b1; cnt_wd = v; step(); cnt_we = 1'b0;
    endtask
    task automatic wr_tgt(input logic [W-1:0] v);
        tgt_we = 1'b1; tgt_wd = v; step(); tgt_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        steps(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 count", 32'(count), 0);
        check("R1 target", 32'(target), 0);
        check("R1 mode", 32'(mode), 0);
        check("R1 irq", 32'(irq), 0);

        // R3 mode write loads data and forces bit 10
        wr_mode(16'h1800);
        check("R3 mode load", 32'(mode), 32'h1C00);
        wr_mode(16'h0000);
        check("R3 mode forced flag", 32'(mode), 32'h0400);

        // R2 counting after a count write
        wr_cnt(16'd5);
        check("R2 count load", 32'(count), 5);
        steps(3);
        check("R2 count advance", 32'(count), 8);

        // R4/R6 reset on target with interrupt
        wr_mode(16'h0018);
        wr_cnt(16'd0);
        wr_tgt(16'd4);
        steps(4);
        check("R4 reach target", 32'(count), 4);
        check("R4 no flag yet", 32'(mode), 32'h0418);
        step();
        check("R4 reset to zero", 32'(count), 0);
        check("R6 flags after target", 32'(mode), 32'h0818);
        check("R6 irq high", 32'(irq), 1);
        step();
        check("R6 irq one cycle", 32'(irq), 0);
        check("R13 target flag sticky", 32'(mode), 32'h0818);

        // R8 zero target never fires
        wr_mode(16'h0018);
        wr_cnt(16'd0);
        wr_tgt(16'd0);
        steps(20);
        check("R8 count runs", 32'(count), 20);
        check("R8 no target flag", 32'(mode), 32'h0418);

        // R9 target equal to count waits for a wrap; R5/R7 overflow without irq
        wr_mode(16'h0008);
        wr_cnt(16'hFFF0);
        wr_tgt(16'hFFF0);
        steps(5);
        check("R9 no early fire count", 32'(count), 32'hFFF5);
        check("R9 no early fire flag", 32'(mode), 32'h0408);
        steps(10);
        check("R5 at max", 32'(count), 32'hFFFF);
        step();
        check("R5 wrapped", 32'(count), 0);
        check("R7 overflow flag only", 32'(mode), 32'h1408);
        check("R7 no irq", 32'(irq), 0);
        steps(3);
        check("R13 overflow flag sticky", 32'(mode), 32'h1408);

        // R12 target and overflow on the same tick
        wr_mode(16'h0038);
        wr_cnt(16'hFFFD);
        wr_tgt(16'hFFFF);
        steps(2);
        check("R12 at max", 32'(count), 32'hFFFF);
        step();
        check("R12 count zero", 32'(count), 0);
        check("R12 both flags", 32'(mode), 32'h1838);
        check("R12 irq", 32'(irq), 1);

        // R11 gate encodings
        wr_mode(16'h0001);
        wr_cnt(16'd7);
        steps(10);
        check("R11 halted 001", 32'(count), 7);
        wr_mode(16'h0007);
        steps(10);
        check("R11 halted 111", 32'(count), 7);
        wr_mode(16'h0002);
        steps(10);
        check("R11 runs 010", 32'(count), 17);

        // R10 alternate clock with two-stage synchroniser
        wr_mode(16'h0100);
        wr_cnt(16'd0);
        steps(4);
        check("R10 idle alt", 32'(count), 0);
        alt_clk = 1'b1;
        steps(2);
        check("R10 sync latency", 32'(count), 0);
        step();
        check("R10 first edge", 32'(count), 1);
        steps(4);
        check("R10 level ignored", 32'(count), 1);
        alt_clk = 1'b0;
        steps(3);
        alt_clk = 1'b1;
        steps(3);
        check("R10 second edge", 32'(count), 2);

        // constrained random phase against the model
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = $urandom % 100;
            if ($urandom % 3 == 0) alt_clk = ~alt_clk;
            if (r < 3) begin
                mode_we = 1'b1; mode_wd = 16'($urandom) & 16'h1D3F;
            end else if (r < 6) begin
                cnt_we = 1'b1;
                cnt_wd = ($urandom % 2 == 0) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom % 64);
            end else if (r < 8) begin
                tgt_we = 1'b1;
                case ($urandom % 3)
                    0: tgt_wd = 16'hFFFF;
                    1: tgt_wd = count + 16'($urandom % 8);
                    default: tgt_wd = 16'($urandom % 64);
                endcase
            end
            step();
            mode_we = 1'b0; cnt_we = 1'b0; tgt_we = 1'b0;
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule